// File: doc/BRIEF.md
# Low-Side Rectifier Mode Controller

This block chooses how the low-side switch of a synchronous buck stage behaves. In continuous conduction the low-side gate simply mirrors the complement of the high-side gate and acts as a synchronous rectifier. In diode emulation the low-side gate is cut as soon as reverse inductor current is seen, so the switch behaves as an ideal diode. Each switching cycle is judged by a phase-polarity comparator (a one-bit input, 1 meaning the phase node is positive, i.e. reverse current). The comparator is only sampled while the high-side gate is low and after a blanking delay. Any positive sample sets a per-cycle latch.

A change of mode needs three consecutive cycles of the same verdict. On entry to diode emulation the block captures a window-voltage step code for the modulator. It can also emit periodic short low-side pulses so that the switching frequency stays above the audible band under very light load. Blanking length, audio period and pulse width are parameters in clock cycles.

Top module: `lsr_mode_ctrl`

## Requirements
- R1: After reset the block is in continuous conduction (`dem_o`=0), `win_step_o`=2'b00, and `ls_en_o` equals the inverse of `hs_gate_i`.
- R2: Diode emulation is entered at the rising edge of `hs_gate_i` that closes the third consecutive cycle judged negative (latch set). After two such cycles the mode is unchanged.
- R3: Continuous conduction is resumed at the rising edge of `hs_gate_i` that closes the third consecutive cycle judged positive (latch never set).
- R4: A cycle whose verdict does not push toward the other mode clears the run of agreeing cycles. The count then starts again from zero.
- R5: Comparator samples at the falling edge of `hs_gate_i` and during the following `BLANK_CYC` clocks are ignored. A cycle whose only positive samples fall there is judged positive.
- R6: The latch is cleared at every rising edge of `hs_gate_i`, so a cycle judged positive right after negative ones still counts as positive.
- R7: In continuous conduction `ls_en_o` is the inverse of `hs_gate_i` whatever the comparator reports.
- R8: In diode emulation `ls_en_o` goes low on the clock after the latch sets. It stays low until the high-side gate rises, except for audio pulses.
- R9: `ls_en_o` is never 1 while `hs_gate_i` is 1.
- R10: `win_step_o` is loaded from `win_cfg_i` at entry to diode emulation: 2'b01 gives +30 % (2'b01), 2'b10 gives +50 % (2'b10), 2'b00 and 2'b11 give no step (2'b00). It holds while in diode emulation even if `win_cfg_i` changes, and reads 2'b00 in continuous conduction.
- R11: In diode emulation with `audio_en_i`=1 and `hs_gate_i` low, `ls_en_o` is forced high for `AUDIO_W` clocks out of every `AUDIO_PER`. With `audio_en_i`=0 no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_gate_i | input | 1 | High-side gate state |
| phase_pos_i | input | 1 | Phase comparator, 1 = positive phase (reverse current) |
| win_cfg_i | input | 2 | Window step requested for diode emulation |
| audio_en_i | input | 1 | Enables anti-audible low-side pulses |
| dem_o | output | 1 | 1 = diode emulation, 0 = continuous conduction |
| ls_en_o | output | 1 | Low-side gate enable |
| win_step_o | output | 2 | Window step select to the modulator |

## Verification
The bench goes after the run counter's boundaries: two agreeing cycles must not switch and the third must. A disagreeing cycle in the middle of a run must restart the count; a design that only counted totals would switch early. Comparator pulses confined to the blanking window must not count, or a mis-sized blank counter would drop the converter into diode emulation on switching noise. A latch not cleared at the high-side rise would carry a negative verdict into a clean cycle. A step code not captured at entry would follow later configuration writes. A misplaced audio timer compare would show as the wrong number of forced low-side clocks.

// File: rtl/lsr_mode_pkg.sv
package lsr_mode_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_P30  = 2'b01,
    STEP_P50  = 2'b10
  } win_step_e;

  function automatic win_step_e map_step(input logic [1:0] cfg);
    case (cfg)
      2'b01:   map_step = STEP_P30;
      2'b10:   map_step = STEP_P50;
      default: map_step = STEP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lsr_polarity_sense.sv
module lsr_polarity_sense #(
  parameter int BLANK_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_gate_i,
  input  logic phase_pos_i,
  output logic cyc_v_o,
  output logic cyc_neg_o,
  output logic latch_o
);
  localparam int BW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

  logic          hs_q;
  logic          armed_q;
  logic          latch_q;
  logic [BW-1:0] blank_q;
  logic          hs_rise, hs_fall, sense_win;

  assign hs_rise   = hs_gate_i & ~hs_q;
  assign hs_fall   = ~hs_gate_i & hs_q;
  assign sense_win = armed_q & ~hs_gate_i & (blank_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q    <= 1'b0;
      armed_q <= 1'b0;
      latch_q <= 1'b0;
      blank_q <= '0;
    end else begin
      hs_q <= hs_gate_i;
      if (hs_rise) begin
        armed_q <= 1'b0;
        latch_q <= 1'b0;
      end else if (hs_fall) begin
        armed_q <= 1'b1;
        latch_q <= 1'b0;
        blank_q <= BW'(BLANK_CYC);
      end else begin
        if (armed_q && !hs_gate_i && blank_q != '0)
          blank_q <= blank_q - 1'b1;
        if (sense_win && phase_pos_i)
          latch_q <= 1'b1;
      end
    end
  end

  // verdict of the low interval just closed
  assign cyc_v_o   = hs_rise & armed_q;
  assign cyc_neg_o = latch_q;
  assign latch_o   = latch_q;

  assert_no_latch_in_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(armed_q && !hs_gate_i && blank_q == '0));

  assert_latch_clear_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_gate_i && !hs_q) |=> !latch_q);

endmodule

// File: rtl/lsr_mode_fsm.sv
module lsr_mode_fsm #(
  parameter int RUN_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_v_i,
  input  logic cyc_neg_i,
  output logic dem_o,
  output logic enter_o,
  output logic exit_o
);
  localparam int CW = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);

  logic          dem_q;
  logic [CW-1:0] run_q;
  logic          toward, last_of_run;

  assign toward      = dem_q ? ~cyc_neg_i : cyc_neg_i;
  assign last_of_run = (run_q == CW'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dem_q <= 1'b0;
      run_q <= '0;
    end else if (cyc_v_i) begin
      if (!toward) begin
        run_q <= '0;
      end else if (last_of_run) begin
        run_q <= '0;
        dem_q <= ~dem_q;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign dem_o   = dem_q;
  assign enter_o = cyc_v_i & toward & last_of_run & ~dem_q;
  assign exit_o  = cyc_v_i & toward & last_of_run & dem_q;

  assert_flip_only_at_run_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dem_q != $past(dem_q)) |-> $past(cyc_v_i));

  assert_run_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < CW'(RUN_LEN));

  assert_run_cleared_on_disagree_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_v_i && !toward) |=> (run_q == '0));

endmodule

// File: rtl/lsr_ls_drive.sv
module lsr_ls_drive #(
  parameter int AUDIO_PER = 3500,
  parameter int AUDIO_W   = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_gate_i,
  input  logic dem_i,
  input  logic latch_i,
  input  logic audio_en_i,
  output logic ls_en_o
);
  localparam int PW = (AUDIO_PER < 2) ? 1 : $clog2(AUDIO_PER);

  logic [PW-1:0] tmr_q;
  logic          tmr_run, pulse;

  assign tmr_run = dem_i & audio_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tmr_q <= '0;
    else if (!tmr_run)                  tmr_q <= '0;
    else if (tmr_q == PW'(AUDIO_PER-1)) tmr_q <= '0;
    else                                tmr_q <= tmr_q + 1'b1;
  end

  assign pulse   = tmr_run & (tmr_q >= PW'(AUDIO_PER - AUDIO_W));
  assign ls_en_o = ~hs_gate_i & (~dem_i | ~latch_i | pulse);

  assert_ls_off_hs_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_gate_i |-> !ls_en_o);

  assert_ls_cut_after_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dem_i && latch_i && !pulse) |-> !ls_en_o);

  assert_no_pulse_disabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!audio_en_i && dem_i && latch_i) |-> !ls_en_o);

endmodule

// File: rtl/lsr_mode_ctrl.sv
module lsr_mode_ctrl
  import lsr_mode_pkg::*;
#(
  parameter int BLANK_CYC = 8,
  parameter int RUN_LEN   = 3,
  parameter int AUDIO_PER = 3500,
  parameter int AUDIO_W   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hs_gate_i,
  input  logic       phase_pos_i,
  input  logic [1:0] win_cfg_i,
  input  logic       audio_en_i,
  output logic       dem_o,
  output logic       ls_en_o,
  output logic [1:0] win_step_o
);
  logic      cyc_v, cyc_neg, latch;
  logic      dem, enter, leave;
  win_step_e step_q;

  lsr_polarity_sense #(.BLANK_CYC(BLANK_CYC)) u_sense (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_gate_i(hs_gate_i), .phase_pos_i(phase_pos_i),
    .cyc_v_o(cyc_v), .cyc_neg_o(cyc_neg), .latch_o(latch)
  );

  lsr_mode_fsm #(.RUN_LEN(RUN_LEN)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_v_i(cyc_v), .cyc_neg_i(cyc_neg),
    .dem_o(dem), .enter_o(enter), .exit_o(leave)
  );

  lsr_ls_drive #(.AUDIO_PER(AUDIO_PER), .AUDIO_W(AUDIO_W)) u_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_gate_i(hs_gate_i), .dem_i(dem),
    .latch_i(latch), .audio_en_i(audio_en_i), .ls_en_o(ls_en_o)
  );

  // step code captured once per entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    step_q <= STEP_NONE;
    else if (enter) step_q <= map_step(win_cfg_i);
    else if (leave) step_q <= STEP_NONE;
  end

  assign dem_o      = dem;
  assign win_step_o = step_q;

  assert_step_none_in_ccm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dem_o |-> (win_step_o == 2'b00));

  assert_step_held_in_dem_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dem_o && $past(dem_o)) |-> $stable(win_step_o));

endmodule

// File: tb/lsr_mode_ctrl_bench.sv
module lsr_mode_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int BLANK   = 3;
  localparam int PER     = 40;
  localparam int PW      = 4;
  localparam int LOWN    = BLANK + 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b1, ph = 1'b0, aen = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic       dem, ls;
  logic [1:0] step;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  lsr_mode_ctrl #(.BLANK_CYC(BLANK), .RUN_LEN(3), .AUDIO_PER(PER), .AUDIO_W(PW)) u_lsr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hs_gate_i(hs), .phase_pos_i(ph), .win_cfg_i(cfg),
    .audio_en_i(aen), .dem_o(dem), .ls_en_o(ls), .win_step_o(step)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 positive, 1 negative, 2 positive phase only inside blanking
  task automatic do_cycle(input int kind, input bit in_dem);
    for (int i = 0; i < LOWN; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 ls on at low start", ls, 1);
      hs = 1'b0;
      ph = (kind == 1) ? 1'b1 : (kind == 2) ? (i <= BLANK) : 1'b0;
    end
    @(negedge clk);
    if (in_dem) chk("R8 ls at low end", ls, (kind == 1) ? 0 : 1);
    else        chk("R7 ls in ccm", ls, 1);
    hs = 1'b1; ph = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ls off with hs", ls, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 dem", dem, 0);
    chk("R1 step", step, 0);
    chk("R1 ls hs high", ls, 0);
  endtask

  task automatic t_enter_r2(input logic [1:0] c, input int exp_step);
    cfg = c;
    do_cycle(1, 0); chk("R2 after 1", dem, 0);
    do_cycle(1, 0); chk("R2 after 2", dem, 0);
    do_cycle(1, 0); chk("R2 after 3", dem, 1);
    chk("R10 step at entry", step, exp_step);
  endtask

  task automatic t_hold_cfg_r10;
    cfg = 2'b10;
    do_cycle(1, 1);
    chk("R10 step held", step, 1);
  endtask

  task automatic t_exit_r3_r4;
    do_cycle(0, 1); do_cycle(0, 1);
    chk("R3 after 2 pos", dem, 1);
    do_cycle(1, 1);
    do_cycle(0, 1); do_cycle(0, 1);
    chk("R4 run restarted", dem, 1);
    do_cycle(0, 1);
    chk("R3 exit on third", dem, 0);
    chk("R10 step none in ccm", step, 0);
  endtask

  task automatic t_ccm_run_r4_r6;
    do_cycle(1, 0); do_cycle(1, 0); do_cycle(0, 0);
    chk("R6 latch cleared, still ccm", dem, 0);
    do_cycle(1, 0); do_cycle(1, 0);
    chk("R4 run restarted in ccm", dem, 0);
    do_cycle(0, 0);
  endtask

  task automatic t_blank_r5;
    for (int k = 0; k < 4; k++) do_cycle(2, 0);
    chk("R5 blanking ignored", dem, 0);
  endtask

  task automatic t_audio_r11;
    int hi;
    @(negedge clk); hs = 1'b0; ph = 1'b1;
    repeat (BLANK + 4) @(negedge clk);
    chk("R8 ls cut, no audio", ls, 0);
    aen = 1'b1;
    hi = 0;
    for (int i = 0; i < 2*PER; i++) begin
      @(negedge clk);
      if (ls) hi++;
    end
    chk("R11 audio pulse clocks", hi, 2*PW);
    aen = 1'b0;
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (ls) hi++;
    end
    chk("R11 no pulse disabled", hi, 0);
    hs = 1'b1; ph = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ls off after audio", ls, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enter_r2(2'b01, 1);
    t_hold_cfg_r10();
    t_exit_r3_r4();
    t_ccm_run_r4_r6();
    t_blank_r5();
    t_enter_r2(2'b10, 2);
    t_audio_r11();
    chk("R2 still dem after audio", dem, 1);
    t_exit_r3_r4();
    t_enter_r2(2'b11, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule